// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a boundary-scan test access port clocked by the test clock. A sixteen-state controller, steered by the mode-select input, walks the instruction and data scan paths. A four-bit instruction register picks which data register sits between the serial input and the serial output. That register is either a one-bit bypass stage or a boundary register made of three cells per pin: input capture, output data and output enable. The decoded instruction also drives three chip-level controls: a chip-wide output disable, an output clamp indication and a reset request to the internal system logic.

Each pin has two sides. Pin-side inputs come from the pads and core-side values come from the functional logic. Depending on the active instruction, the pin outputs either pass the core values through or are driven from the update stage of the boundary cells. The boundary cells can be preloaded without disturbing the pins, so known values appear as soon as the external-test instruction is loaded. The test clock and the system clock are not synchronised with each other.

Top module: `tap_scan_ctrl`

## Requirements
- R1: After the asynchronous test reset is released, the active instruction is all ones and behaves as bypass. `pad_out` equals `core_out`, `pad_oe` equals `core_oe`, and `sys_rst`, `out_disable`, `clamp_act` and `tdo_oe` are all low.
- R2: In Capture-IR the instruction shift stage loads 0101. During Shift-IR it shifts out least significant bit first, so the first four bits seen on `tdo` are 1, 0, 1, 0.
- R3: Opcodes 0x1x and every opcode with bit 3 set decode as bypass. The pins pass the core values and all three chip-level controls stay low.
- R4: Opcode 0000 (external test) puts the boundary register in the scan path, raises `sys_rst`, and drives `pad_out[p]` and `pad_oe[p]` from the update stage of boundary bits 3p+1 and 3p+2. Capture-DR loads `pad_in[p]`, `core_out[p]` and `core_oe[p]` into bits 3p, 3p+1 and 3p+2. Bit 0 is nearest `tdo` and `tdi` enters at the top bit.
- R5: The bypass register captures 0 in Capture-DR and delays `tdi` by one clock in Shift-DR.
- R6: Opcode 0001 (sample/preload) puts the boundary register in the path with the R4 bit layout. It captures the R4 snapshot and takes new update-stage values, while the pins keep passing the core values and `sys_rst` stays low.
- R7: Opcode 0100 selects the bypass register, forces every `pad_oe` bit low, passes `core_out` to `pad_out` and raises `out_disable`.
- R8: Opcode 0101 selects the bypass register, drives the pins from the boundary update stage as in R4, raises `clamp_act` and keeps `sys_rst` low.
- R9: Five consecutive clocks with `tms` high reach Test-Logic-Reset from any state, and an asserted `trst_n` does so at once. Either way the active instruction returns to bypass, and four such clocks from Shift-DR are not enough.
- R10: `tdo` changes only on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R11: The active instruction changes only in Update-IR or Test-Logic-Reset. The boundary update stage changes only in Update-DR, so pin values hold while new data is shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, updated on the falling edge |
| tdo_oe | output | 1 | High while serial output data is valid |
| pad_in | input | NPIN | Values present at the pins |
| core_out | input | NPIN | Output data from the functional logic |
| core_oe | input | NPIN | Output enables from the functional logic |
| pad_out | output | NPIN | Output data toward the pins |
| pad_oe | output | NPIN | Output enables toward the pins |
| out_disable | output | 1 | Chip-wide output disable |
| clamp_act | output | 1 | Pins are held from the boundary update stage while bypass is selected |
| sys_rst | output | 1 | Reset request to the internal system logic |

## Verification
A controller stuck in or skipping a state shows up as a wrong bit count or ordering on `tdo`. That error is visible on the first falling edge in Shift-IR or Shift-DR, where the captured 1-0-1-0 pattern or the leading bypass zero lands in the wrong place. A wrong decode or a corrupt instruction hold shows on `sys_rst`, `out_disable`, `clamp_act` and the pin mux in the cycle after Update-IR. A boundary update stage that changes outside Update-DR shows as pins that move while data is still being shifted, which is caught at Exit1-DR before the update.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET,  ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_st_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_HIZ     = 4'b0100;
    localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0101;
    localparam logic [IR_W-1:0] OP_DEFAULT = 4'b1111;

    typedef enum logic [2:0] {
        INS_EXTEST, INS_SAMPLE, INS_BYPASS, INS_HIZ, INS_CLAMP
    } ins_e;

    // Anything not explicitly listed falls back to bypass.
    function automatic ins_e decode_op(logic [IR_W-1:0] op);
        ins_e r;
        casez (op)
            4'b1???: r = INS_BYPASS;
            4'b0000: r = INS_EXTEST;
            4'b0001: r = INS_SAMPLE;
            4'b0100: r = INS_HIZ;
            4'b0101: r = INS_CLAMP;
            default: r = INS_BYPASS;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tap_scan_fsm.sv
module tap_scan_fsm
    import tap_scan_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tms,
    output tap_st_e st_o
);

    typedef struct packed {
        tap_st_e st;
    } fsm_s;

    fsm_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_RESET:  r_d.st = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   r_d.st = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: r_d.st = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: r_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  r_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: r_d.st = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: r_d.st = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: r_d.st = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: r_d.st = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: r_d.st = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: r_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  r_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: r_d.st = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: r_d.st = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: r_d.st = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: r_d.st = tms ? ST_SEL_DR : ST_IDLE;
            default:   r_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{st: ST_RESET};
        else         r_q <= r_d;
    end

    assign st_o = r_q.st;

endmodule

// File: rtl/tap_scan_ir.sv
module tap_scan_ir
    import tap_scan_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_st_e         st,
    output logic            so,
    output logic [IR_W-1:0] hold_o,
    output logic [IR_W-1:0] eff_o,
    output ins_e            ins_o
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] hold;
    } ir_s;

    ir_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (st)
            ST_CAP_IR: r_d.sh   = OP_CLAMP;
            ST_SH_IR:  r_d.sh   = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR: r_d.hold = r_q.sh;
            ST_RESET:  r_d.hold = OP_DEFAULT;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sh: '0, hold: OP_DEFAULT};
        else         r_q <= r_d;
    end

    // Test-Logic-Reset forces the default at once, without waiting a clock.
    assign eff_o  = (st == ST_RESET) ? OP_DEFAULT : r_q.hold;
    assign ins_o  = decode_op(eff_o);
    assign hold_o = r_q.hold;
    assign so     = r_q.sh[0];

endmodule

// File: rtl/tap_scan_bsr.sv
module tap_scan_bsr
    import tap_scan_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_st_e         st,
    input  logic            sel,
    input  logic [NPIN-1:0] pad_in,
    input  logic [NPIN-1:0] core_out,
    input  logic [NPIN-1:0] core_oe,
    output logic            so,
    output logic [NPIN-1:0] up_out,
    output logic [NPIN-1:0] up_oe
);

    localparam int CELLS = 3;
    localparam int LEN   = CELLS * NPIN;

    typedef struct packed {
        logic [LEN-1:0]  sh;
        logic [NPIN-1:0] u_out;
        logic [NPIN-1:0] u_oe;
    } bsr_s;

    bsr_s r_d, r_q;

    logic [LEN-1:0]  cap_v;
    logic [NPIN-1:0] sh_out_f;
    logic [NPIN-1:0] sh_oe_f;

    for (genvar g = 0; g < NPIN; g++) begin : g_cell
        assign cap_v[CELLS*g]     = pad_in[g];
        assign cap_v[CELLS*g + 1] = core_out[g];
        assign cap_v[CELLS*g + 2] = core_oe[g];
        assign sh_out_f[g]        = r_q.sh[CELLS*g + 1];
        assign sh_oe_f[g]         = r_q.sh[CELLS*g + 2];
    end

    always_comb begin
        r_d = r_q;
        if (sel) begin
            case (st)
                ST_CAP_DR: r_d.sh = cap_v;
                ST_SH_DR:  r_d.sh = {tdi, r_q.sh[LEN-1:1]};
                ST_UPD_DR: begin
                    r_d.u_out = sh_out_f;
                    r_d.u_oe  = sh_oe_f;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign so     = r_q.sh[0];
    assign up_out = r_q.u_out;
    assign up_oe  = r_q.u_oe;

endmodule

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl
    import tap_scan_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    input  logic [NPIN-1:0] pad_in,
    input  logic [NPIN-1:0] core_out,
    input  logic [NPIN-1:0] core_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic            out_disable,
    output logic            clamp_act,
    output logic            sys_rst
);

    tap_st_e         st;
    ins_e            ins;
    logic [IR_W-1:0] ir_hold;
    logic [IR_W-1:0] ir_eff;
    logic            ir_so;
    logic            bsr_so;
    logic            sel_bsr;
    logic [NPIN-1:0] up_out;
    logic [NPIN-1:0] up_oe;

    tap_scan_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .st_o   (st)
    );

    tap_scan_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .st     (st),
        .so     (ir_so),
        .hold_o (ir_hold),
        .eff_o  (ir_eff),
        .ins_o  (ins)
    );

    assign sel_bsr = (ins == INS_EXTEST) || (ins == INS_SAMPLE);

    tap_scan_bsr #(.NPIN(NPIN)) u_bsr (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .st       (st),
        .sel      (sel_bsr),
        .pad_in   (pad_in),
        .core_out (core_out),
        .core_oe  (core_oe),
        .so       (bsr_so),
        .up_out   (up_out),
        .up_oe    (up_oe)
    );

    // Bypass stage, rising edge.
    typedef struct packed {
        logic byp;
    } pos_s;

    pos_s p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (!sel_bsr) begin
            if (st == ST_CAP_DR)     p_d.byp = 1'b0;
            else if (st == ST_SH_DR) p_d.byp = tdi;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) p_q <= '0;
        else         p_q <= p_d;
    end

    // Serial output stage, falling edge.
    typedef struct packed {
        logic dat;
        logic oe;
    } neg_s;

    neg_s n_d, n_q;
    logic in_shift;
    logic ser;

    assign in_shift = (st == ST_SH_IR) || (st == ST_SH_DR);
    assign ser      = (st == ST_SH_IR) ? ir_so : (sel_bsr ? bsr_so : p_q.byp);

    always_comb begin
        n_d    = n_q;
        n_d.oe = in_shift;
        if (in_shift) n_d.dat = ser;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) n_q <= '0;
        else         n_q <= n_d;
    end

    assign tdo    = n_q.dat;
    assign tdo_oe = n_q.oe;

    // Pin steering.
    logic from_cells;
    assign from_cells  = (ins == INS_EXTEST) || (ins == INS_CLAMP);
    assign pad_out     = from_cells ? up_out : core_out;
    assign pad_oe      = (ins == INS_HIZ) ? '0 : (from_cells ? up_oe : core_oe);
    assign sys_rst     = (ins == INS_EXTEST);
    assign out_disable = (ins == INS_HIZ);
    assign clamp_act   = (ins == INS_CLAMP);

endmodule

// File: rtl/tap_scan_ctrl_chk.sv
module tap_scan_ctrl_chk
    import tap_scan_pkg::*;
#(
    parameter int NPIN = 4
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_st_e         st,
    input logic [IR_W-1:0] ir_hold,
    input logic [IR_W-1:0] ir_eff,
    input logic            sys_rst,
    input logic            out_disable,
    input logic [NPIN-1:0] pad_oe,
    input logic            tdo_oe,
    input logic [NPIN-1:0] up_out,
    input logic [NPIN-1:0] up_oe
);

    logic [2:0] run_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)             run_q <= '0;
        else if (!tms)           run_q <= '0;
        else if (run_q != 3'd5)  run_q <= run_q + 3'd1;
    end

    a_r4_extest_sysrst: assert property (@(posedge tck) disable iff (!trst_n)
        sys_rst |-> (ir_eff == OP_EXTEST));

    a_r4_extest_pins: assert property (@(posedge tck) disable iff (!trst_n)
        sys_rst |-> (pad_oe == up_oe));

    a_r7_hiz_no_drive: assert property (@(posedge tck) disable iff (!trst_n)
        out_disable |-> (pad_oe == '0));

    a_r9_reset_default: assert property (@(posedge tck) disable iff (!trst_n)
        (st == ST_RESET) |=> (ir_hold == OP_DEFAULT));

    a_r9_five_tms_high: assert property (@(posedge tck) disable iff (!trst_n)
        (run_q == 3'd5) |-> (st == ST_RESET));

    a_r10_tdo_oe_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> ((st == ST_SH_IR) || (st == ST_SH_DR)));

    a_r11_ir_stable: assert property (@(posedge tck) disable iff (!trst_n)
        !((st == ST_UPD_IR) || (st == ST_RESET)) |=> $stable(ir_hold));

    a_r11_bsr_stable: assert property (@(posedge tck) disable iff (!trst_n)
        (st != ST_UPD_DR) |=> ($stable(up_out) && $stable(up_oe)));

endmodule

bind tap_scan_ctrl tap_scan_ctrl_chk #(.NPIN(NPIN)) u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .st          (st),
    .ir_hold     (ir_hold),
    .ir_eff      (ir_eff),
    .sys_rst     (sys_rst),
    .out_disable (out_disable),
    .pad_oe      (pad_oe),
    .tdo_oe      (tdo_oe),
    .up_out      (up_out),
    .up_oe       (up_oe)
);

// File: tb/tap_scan_ctrl_test.sv
module tap_scan_ctrl_test;

    localparam int NP = 4;
    localparam int L  = 3 * NP;

    logic          tck = 1'b0;
    logic          trst_n, tms, tdi;
    logic [NP-1:0] pad_in, core_out, core_oe;
    logic          tdo, tdo_oe, out_disable, clamp_act, sys_rst;
    logic [NP-1:0] pad_out, pad_oe;

    always #10 tck = ~tck;

    tap_scan_ctrl #(.NPIN(NP)) uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe),
        .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .out_disable(out_disable), .clamp_act(clamp_act), .sys_rst(sys_rst)
    );

    int checks = 0;
    int errors = 0;
    bit cap_active = 1'b0;
    bit done = 1'b0;
    logic last_tdo = 1'b0;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic chk_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cap_vec(logic [NP-1:0] pi, logic [NP-1:0] co, logic [NP-1:0] ce);
        logic [31:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            v[3*p]     = pi[p];
            v[3*p + 1] = co[p];
            v[3*p + 2] = ce[p];
        end
        return v;
    endfunction

    function automatic logic [31:0] pre_vec(logic [NP-1:0] o, logic [NP-1:0] e);
        logic [31:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            v[3*p]     = 1'b1;
            v[3*p + 1] = o[p];
            v[3*p + 2] = e[p];
        end
        return v;
    endfunction

    function automatic logic [31:0] byp_vec(logic [31:0] din, int n);
        logic [31:0] v = '0;
        for (int i = 1; i < n; i++) v[i] = din[i-1];
        return v;
    endfunction

    // Driver: one test clock; inputs change just after the falling edge.
    task automatic step(bit m, bit d, bit c);
        @(negedge tck);
        #2;
        cap_active = c;
        tms = m;
        tdi = d;
    endtask

    // Monitor: pops the scoreboard on every captured bit.
    always @(negedge tck) begin
        #3;
        if (cap_active) begin
            if (sb_q.size() == 0) begin
                chk_eq("R10", "scan bit with empty scoreboard", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk_eq(e.tag, "tdo bit", {31'd0, tdo}, {31'd0, e.v});
                chk_eq("R10", "tdo_oe while shifting", {31'd0, tdo_oe}, 32'd1);
            end
            last_tdo = tdo;
        end
    end

    always @(posedge tck) begin
        #1;
        if (cap_active) chk_eq("R10", "tdo held across rising edge", {31'd0, tdo}, {31'd0, last_tdo});
    end

    task automatic push_bits(logic [31:0] v, int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v = v[i];
            e.tag = tag;
            sb_q.push_back(e);
        end
    endtask

    // From Run-Test/Idle, load an opcode and return to Run-Test/Idle.
    task automatic load_ir(logic [3:0] op);
        logic [NP-1:0] so_out, so_oe;
        logic          s_rst;
        so_out = pad_out; so_oe = pad_oe; s_rst = sys_rst;
        step(1, 0, 0);
        step(1, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        push_bits(32'b0101, 4, "R2");
        for (int i = 0; i < 4; i++) step(i == 3, op[i], 1);
        step(1, 0, 0);
        chk_eq("R11", "pad_out before Update-IR", pad_out, so_out);
        chk_eq("R11", "pad_oe before Update-IR", pad_oe, so_oe);
        chk_eq("R11", "sys_rst before Update-IR", sys_rst, s_rst);
        step(0, 0, 0);
        step(0, 0, 0);
    endtask

    task automatic dr_scan(int n, logic [31:0] din, logic [31:0] expv, string tag, bit hold_chk);
        logic [NP-1:0] so_out, so_oe;
        so_out = pad_out; so_oe = pad_oe;
        push_bits(expv, n, tag);
        step(1, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i], 1);
        step(1, 0, 0);
        if (hold_chk) begin
            chk_eq("R11", "pad_out before Update-DR", pad_out, so_out);
            chk_eq("R11", "pad_oe before Update-DR", pad_oe, so_oe);
        end
        step(0, 0, 0);
        step(0, 0, 0);
    endtask

    task automatic pins_normal(string tag);
        chk_eq(tag, "pad_out passes core", pad_out, core_out);
        chk_eq(tag, "pad_oe passes core", pad_oe, core_oe);
        chk_eq(tag, "sys_rst low", sys_rst, 0);
        chk_eq(tag, "out_disable low", out_disable, 0);
        chk_eq(tag, "clamp_act low", clamp_act, 0);
    endtask

    initial begin
        tms = 1'b1; tdi = 1'b0; trst_n = 1'b0;
        pad_in = 4'b1010; core_out = 4'b0110; core_oe = 4'b1100;
        #45 trst_n = 1'b1;

        // R1 reset state
        pins_normal("R1");
        chk_eq("R1", "tdo_oe after reset", tdo_oe, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        chk_eq("R10", "tdo_oe in idle", tdo_oe, 0);

        // R1/R5 default instruction is bypass
        dr_scan(3, 32'b101, byp_vec(32'b101, 3), "R5", 1'b0);
        pins_normal("R1");

        // R6 sample and preload
        load_ir(4'b0001);
        pins_normal("R6");
        dr_scan(L, pre_vec(4'b1001, 4'b0111), cap_vec(pad_in, core_out, core_oe), "R6", 1'b1);
        pins_normal("R6");

        // R4 external test
        load_ir(4'b0000);
        chk_eq("R4", "pad_out from preload", pad_out, 4'b1001);
        chk_eq("R4", "pad_oe from preload", pad_oe, 4'b0111);
        chk_eq("R4", "sys_rst high", sys_rst, 1);
        pad_in = 4'b0101;
        dr_scan(L, pre_vec(4'b0110, 4'b1110), cap_vec(4'b0101, core_out, core_oe), "R4", 1'b1);
        chk_eq("R11", "pad_out after Update-DR", pad_out, 4'b0110);
        chk_eq("R11", "pad_oe after Update-DR", pad_oe, 4'b1110);

        // R7 outputs disabled
        load_ir(4'b0100);
        chk_eq("R7", "pad_oe all low", pad_oe, 0);
        chk_eq("R7", "out_disable high", out_disable, 1);
        chk_eq("R7", "pad_out passes core", pad_out, core_out);
        chk_eq("R7", "sys_rst low", sys_rst, 0);
        dr_scan(4, 32'b1101, byp_vec(32'b1101, 4), "R7", 1'b0);

        // R8 clamp
        load_ir(4'b0101);
        chk_eq("R8", "pad_out from cells", pad_out, 4'b0110);
        chk_eq("R8", "pad_oe from cells", pad_oe, 4'b1110);
        chk_eq("R8", "clamp_act high", clamp_act, 1);
        chk_eq("R8", "sys_rst low", sys_rst, 0);
        dr_scan(4, 32'b0110, byp_vec(32'b0110, 4), "R8", 1'b0);

        // R3 other opcodes fall back to bypass
        load_ir(4'b1010);
        pins_normal("R3");
        dr_scan(2, 32'b11, byp_vec(32'b11, 2), "R3", 1'b0);
        load_ir(4'b0011);
        pins_normal("R3");
        dr_scan(3, 32'b010, byp_vec(32'b010, 3), "R3", 1'b0);

        // R9 five clocks with tms high from Shift-DR
        load_ir(4'b0000);
        chk_eq("R9", "extest active before walk", sys_rst, 1);
        step(1, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            step(1, 0, 0);
            if (i == 4) chk_eq("R9", "four tms-high clocks keep extest", sys_rst, 1);
        end
        step(0, 0, 0);
        pins_normal("R9");
        step(0, 0, 0);
        dr_scan(2, 32'b10, byp_vec(32'b10, 2), "R5", 1'b0);

        // R9 asynchronous test reset
        load_ir(4'b0000);
        chk_eq("R9", "extest before trst", sys_rst, 1);
        @(negedge tck);
        #5 trst_n = 1'b0;
        #1;
        pins_normal("R9");
        chk_eq("R9", "tdo_oe low in reset", tdo_oe, 0);
        #20 trst_n = 1'b1;
        step(0, 0, 0);
        chk_eq("R2", "scoreboard drained", sb_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            chk_eq("R10", "watchdog expired", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule